// File: doc/BRIEF.md
# Programmable Four-Element Logic Cluster

This block is one tile of a programmable logic fabric. It takes ten general inputs and produces four outputs. Inside are four logic elements, each built from a four-input lookup table and a D flip-flop. A complete local crossbar drives all sixteen table input pins. Each pin can take any of the ten cluster inputs, any of the four element outputs fed back, or a constant zero. Each element sends to its output either the raw table value or the registered one. Element k drives output k.

All configuration sits in one serial shift chain of 132 bits. The chain holds the crossbar selects, the per-element output selects and the sixteen-bit truth tables. Loading happens one bit per clock while the shift enable is high. The chain's oldest bit appears on a serial output so that tiles can be daisy-chained. A synchronous reset clears the four flip-flops and leaves the configuration alone.

Top module: `lc_cluster`

## Requirements
- R1: While `cfg_en` is high, every rising clock edge shifts the chain by one place toward higher positions, and `cfg_si` enters at position 0. While `cfg_en` is low the chain holds its contents.
- R2: `cfg_so` always shows chain position 131, so after a full 132-bit load it carries the first bit shifted in. Each further shift then exposes the next older bit.
- R3: Chain layout. Bits [4p+3:4p] are the crossbar select of table pin p, where p = 4·element + input index. Bit 64+k is the output select of element k (1 = registered). Bits [68+16k+15:68+16k] are element k's truth table.
- R4: A table outputs bit {in3,in2,in1,in0} of its sixteen-bit truth table, with pin 0 as the least significant index bit.
- R5: Select codes 0 to 9 pick cluster inputs 0 to 9. Codes 10 to 13 pick element outputs 0 to 3. Codes 14 and 15 give constant 0.
- R6: With output select 0, `pin_out[k]` follows element k's table value within the same cycle.
- R7: Every flip-flop loads its own table value at each rising edge when reset is low. With output select 1, `pin_out[k]` shows that flip-flop.
- R8: With `rst` high at a rising edge, all four flip-flops clear to 0. The configuration is unchanged, so the loaded function still applies after reset.
- R9: When unregistered elements feed each other through the crossbar without forming a loop, a chain up to four elements deep settles to the correct value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock for the chain and the flip-flops |
| rst | input | 1 | Synchronous clear of the element flip-flops |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_si | input | 1 | Serial configuration data in |
| pin_in | input | 10 | General cluster inputs |
| pin_out | output | 4 | Element outputs, one per element |
| cfg_so | output | 1 | Serial configuration data out (chain position 131) |

## Verification
The assertions assume that loading and operation do not overlap: flip-flop capture and the chain tail are only meaningful once `rst` is low, and the chain holds whenever `cfg_en` is low. They also assume the configuration never closes a loop of unregistered elements, since such a loop has no settled value. The stimulus loads each configuration completely with `cfg_en` high and then resets before checking any function. Its random configuration generator rewrites any feedback select that would let an unregistered element read itself or a higher-numbered unregistered element.

// File: rtl/lc_pkg.sv
package lc_pkg;
    localparam int unsigned LC_N_IN   = 10;
    localparam int unsigned LC_N_ELEM = 4;
    localparam int unsigned LC_K      = 4;
endpackage

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
    parameter int unsigned W = 132
) (
    input  logic         clk,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] image,
    output logic         bit_out
);
    typedef struct packed {
        logic [W-1:0] img;
    } chain_t;

    chain_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (shift_en) begin
            ch_d.img = {ch_q.img[W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk) begin
        ch_q <= ch_d;
    end

    assign image   = ch_q.img;
    assign bit_out = ch_q.img[W-1];
endmodule

// File: rtl/lc_xbar_pin.sv
module lc_xbar_pin #(
    parameter int unsigned N_IN   = 10,
    parameter int unsigned N_ELEM = 4,
    parameter int unsigned SEL_W  = 4
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [N_IN-1:0]   src_in,
    input  logic [N_ELEM-1:0] src_fb,
    output logic              pin
);
    localparam int unsigned N_SRC = N_IN + N_ELEM;

    logic [N_SRC-1:0] sources;

    assign sources = {src_fb, src_in};

    always_comb begin
        pin = 1'b0;
        for (int s = 0; s < int'(N_SRC); s++) begin
            if (sel == SEL_W'(s)) begin
                pin = sources[s];
            end
        end
    end
endmodule

// File: rtl/lc_lut.sv
module lc_lut #(
    parameter int unsigned K = 4
) (
    input  logic [(1<<K)-1:0] tt,
    input  logic [K-1:0]      idx,
    output logic              y
);
    assign y = tt[idx];
endmodule

// File: rtl/lc_cluster.sv
module lc_cluster #(
    parameter int unsigned N_IN   = lc_pkg::LC_N_IN,
    parameter int unsigned N_ELEM = lc_pkg::LC_N_ELEM,
    parameter int unsigned K      = lc_pkg::LC_K
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_si,
    input  logic [N_IN-1:0]   pin_in,
    output logic [N_ELEM-1:0] pin_out,
    output logic              cfg_so
);
    localparam int unsigned N_SRC   = N_IN + N_ELEM;
    localparam int unsigned SEL_W   = $clog2(N_SRC + 1);
    localparam int unsigned N_PIN   = N_ELEM * K;
    localparam int unsigned TT_W    = 1 << K;
    localparam int unsigned OS_BASE = N_PIN * SEL_W;
    localparam int unsigned TT_BASE = OS_BASE + N_ELEM;
    localparam int unsigned CFG_W   = TT_BASE + N_ELEM * TT_W;
    localparam int unsigned N_PASS  = N_ELEM;

    typedef struct packed {
        logic [N_ELEM-1:0] ff;
    } elem_state_t;

    logic [CFG_W-1:0]           cfg_image;
    logic [N_ELEM-1:0]          osel;
    logic [N_ELEM-1:0]          ff_q;
    logic [N_ELEM-1:0]          lut_final;
    logic [(N_PASS+1)*N_ELEM-1:0] fb_flat;
    logic [N_PASS*N_ELEM-1:0]     lut_flat;
    elem_state_t                st_d, st_q;

    lc_cfg_chain #(.W(CFG_W)) u_chain (
        .clk      (clk),
        .shift_en (cfg_en),
        .bit_in   (cfg_si),
        .image    (cfg_image),
        .bit_out  (cfg_so)
    );

    assign osel = cfg_image[OS_BASE +: N_ELEM];
    assign ff_q = st_q.ff;

    // Pass 0 starts from registered values only; each later pass resolves
    // one more level of unregistered feedback.
    assign fb_flat[0 +: N_ELEM] = osel & ff_q;

    for (genvar p = 0; p < N_PASS; p++) begin : g_pass
        for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
            logic [K-1:0] idx;
            for (genvar i = 0; i < K; i++) begin : g_pin
                lc_xbar_pin #(
                    .N_IN   (N_IN),
                    .N_ELEM (N_ELEM),
                    .SEL_W  (SEL_W)
                ) u_xb (
                    .sel    (cfg_image[(e*K + i)*SEL_W +: SEL_W]),
                    .src_in (pin_in),
                    .src_fb (fb_flat[p*N_ELEM +: N_ELEM]),
                    .pin    (idx[i])
                );
            end
            lc_lut #(.K(K)) u_lut (
                .tt  (cfg_image[TT_BASE + e*TT_W +: TT_W]),
                .idx (idx),
                .y   (lut_flat[p*N_ELEM + e])
            );
            assign fb_flat[(p+1)*N_ELEM + e] =
                osel[e] ? ff_q[e] : lut_flat[p*N_ELEM + e];
        end
    end

    assign lut_final = lut_flat[(N_PASS-1)*N_ELEM +: N_ELEM];

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.ff = '0;
        end else begin
            st_d.ff = lut_final;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pin_out = (osel & ff_q) | (~osel & lut_final);
endmodule

// File: rtl/lc_cluster_chk.sv
module lc_cluster_chk #(
    parameter int unsigned N_ELEM = 4,
    parameter int unsigned CFG_W  = 132
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_en,
    input logic              cfg_so,
    input logic [CFG_W-1:0]  cfg_image,
    input logic [N_ELEM-1:0] ff_q,
    input logic [N_ELEM-1:0] lut_final
);
    // R1: chain contents hold while shifting is disabled
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_image));

    // R2: the serial tail takes the bit that sat just below it
    p_cfg_tail_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> cfg_so == $past(cfg_image[CFG_W-2]));

    // R7: each flip-flop captures its table value
    p_ff_capture_r7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ff_q == $past(lut_final));

    // R8: reset clears every flip-flop (the property is about reset itself)
    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> ff_q == '0);
endmodule

bind lc_cluster lc_cluster_chk #(
    .N_ELEM (N_ELEM),
    .CFG_W  (CFG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (cfg_en),
    .cfg_so    (cfg_so),
    .cfg_image (cfg_image),
    .ff_q      (ff_q),
    .lut_final (lut_final)
);

// File: tb/tb_lc_cluster.sv
module tb_lc_cluster;
    localparam int CLK_PERIOD = 10;
    localparam int NI  = 10;
    localparam int NE  = 4;
    localparam int OSB = 64;
    localparam int TTB = 68;
    localparam int CW  = 132;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_en = 1'b0;
    logic          cfg_si = 1'b0;
    logic [NI-1:0] pin_in = '0;
    logic [NE-1:0] pin_out;
    logic          cfg_so;

    logic [CW-1:0] cfg_m;
    logic [NE-1:0] ff_m;
    int n_chk  = 0;
    int n_fail = 0;

    lc_cluster dut (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_si  (cfg_si),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .cfg_so  (cfg_so)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic src_val(input logic [3:0] code, input logic [NI-1:0] ci,
                                     input logic [NE-1:0] fb);
        if (code < 4'd10) return ci[code];
        if (code < 4'd14) return fb[code - 4'd10];
        return 1'b0;
    endfunction

    function automatic logic [NE-1:0] model_lut(input logic [CW-1:0] c,
                                                input logic [NI-1:0] ci,
                                                input logic [NE-1:0] ffq);
        logic [NE-1:0] os = c[OSB +: NE];
        logic [NE-1:0] fb = os & ffq;
        logic [NE-1:0] lv = '0;
        for (int pass = 0; pass < NE; pass++) begin
            for (int e = 0; e < NE; e++) begin
                logic [3:0] ix;
                for (int i = 0; i < 4; i++) ix[i] = src_val(c[(e*4+i)*4 +: 4], ci, fb);
                lv[e] = c[TTB + e*16 + int'(ix)];
            end
            fb = (os & ffq) | (~os & lv);
        end
        return lv;
    endfunction

    function automatic logic [NE-1:0] model_out(input logic [CW-1:0] c,
                                                input logic [NI-1:0] ci,
                                                input logic [NE-1:0] ffq);
        logic [NE-1:0] os = c[OSB +: NE];
        return (os & ffq) | (~os & model_lut(c, ci, ffq));
    endfunction

    function automatic logic [CW-1:0] pack_cfg(input logic [63:0] sels,
                                               input logic [NE-1:0] os,
                                               input logic [63:0] tts);
        return {tts, os, sels};
    endfunction

    function automatic logic [CW-1:0] rand_cfg(input logic [NE-1:0] os);
        logic [63:0] sels;
        logic [63:0] tts;
        for (int e = 0; e < NE; e++) begin
            tts[e*16 +: 16] = 16'($urandom);
            for (int i = 0; i < 4; i++) begin
                logic [3:0] code = 4'($urandom % 16);
                if (code >= 4'd10 && code <= 4'd13) begin
                    int j = int'(code) - 10;
                    if (!os[j] && j >= e) code = 4'($urandom % 10);
                end
                sels[(e*4+i)*4 +: 4] = code;
            end
        end
        return pack_cfg(sels, os, tts);
    endfunction

    // All tasks start and end just after a falling edge.
    task automatic load(input logic [CW-1:0] v);
        for (int b = CW-1; b >= 0; b--) begin
            cfg_en = 1'b1;
            cfg_si = v[b];
            @(negedge clk);
        end
        cfg_en = 1'b0;
        cfg_m  = v;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst  = 1'b0;
        ff_m = '0;
    endtask

    task automatic step(input logic [NI-1:0] ci, input string req);
        logic [NE-1:0] nxt;
        pin_in = ci;
        #1;
        chk(req, 32'(pin_out), 32'(model_out(cfg_m, ci, ff_m)));
        nxt = model_lut(cfg_m, ci, ff_m);
        @(negedge clk);
        ff_m = nxt;
    endtask

    initial begin
        logic [CW-1:0] v;
        logic [63:0] sels;
        void'($urandom(32'h5EED_0042));
        @(negedge clk);

        // R8: reset with every element registered gives all-zero outputs
        v = rand_cfg(4'hF);
        load(v);
        do_reset();
        #1;
        chk("R8 reset state", 32'(pin_out), 32'h0);

        // R2 / R3: the first bit shifted in sits at the tail
        chk("R2 tail after load", 32'(cfg_so), 32'(v[CW-1]));

        // R1: holding cfg_en low keeps the configuration
        for (int n = 0; n < 20; n++) step(10'($urandom), "R1 hold");
        chk("R1 tail held", 32'(cfg_so), 32'(v[CW-1]));

        // R1 / R2: each extra shift exposes the next older bit
        for (int j = 1; j <= 6; j++) begin
            cfg_en = 1'b1;
            cfg_si = 1'b0;
            @(negedge clk);
            cfg_en = 1'b0;
            chk("R2 shift order", 32'(cfg_so), 32'(v[CW-1-j]));
        end

        // R4 / R3: element k's pin i selects input i; table for pin k
        sels = '0;
        for (int e = 0; e < NE; e++)
            for (int i = 0; i < 4; i++) sels[(e*4+i)*4 +: 4] = 4'(i);
        load(pack_cfg(sels, 4'h0, {16'hFF00, 16'hF0F0, 16'hCCCC, 16'hAAAA}));
        do_reset();
        for (int n = 0; n < 12; n++) begin
            logic [NI-1:0] ci = 10'($urandom);
            pin_in = ci;
            #1;
            chk("R4 index order", 32'(pin_out), 32'(ci[3:0]));
            @(negedge clk);
        end

        // R5: inputs 9..6 feeding an AND table
        for (int e = 0; e < NE; e++)
            for (int i = 0; i < 4; i++) sels[(e*4+i)*4 +: 4] = 4'(9 - i);
        load(pack_cfg(sels, 4'h0, {4{16'h8000}}));
        do_reset();
        for (int n = 0; n < 8; n++) begin
            logic [NI-1:0] ci = (n == 0) ? 10'h3C0 : 10'($urandom);
            pin_in = ci;
            #1;
            chk("R5 upper inputs", 32'(pin_out), {28'h0, {4{&ci[9:6]}}});
            @(negedge clk);
        end

        // R5: codes 14 and 15 feed constant zero, table bit 0 set
        for (int p = 0; p < 16; p++) sels[p*4 +: 4] = (p % 2 == 0) ? 4'd14 : 4'd15;
        load(pack_cfg(sels, 4'h0, {4{16'h0001}}));
        do_reset();
        for (int n = 0; n < 4; n++) begin
            pin_in = (n == 0) ? 10'h3FF : 10'($urandom);
            #1;
            chk("R5 constant codes", 32'(pin_out), 32'hF);
            @(negedge clk);
        end

        // R9: unregistered chain in0 -> e0 -> ~ -> ~ -> ~
        for (int p = 0; p < 16; p++) sels[p*4 +: 4] = 4'd14;
        sels[0*16 +: 4] = 4'd0;
        sels[1*16 +: 4] = 4'd10;
        sels[2*16 +: 4] = 4'd11;
        sels[3*16 +: 4] = 4'd12;
        load(pack_cfg(sels, 4'h0, {16'h5555, 16'h5555, 16'h5555, 16'hAAAA}));
        do_reset();
        for (int n = 0; n < 4; n++) begin
            logic b = n[0];
            pin_in = {9'h0, b};
            #1;
            chk("R9 chain depth", 32'(pin_out), {28'h0, ~b, b, ~b, b});
            @(negedge clk);
        end

        // R7: registered element lags its input by one clock
        for (int p = 0; p < 16; p++) sels[p*4 +: 4] = 4'd15;
        for (int e = 0; e < NE; e++) sels[(e*4)*4 +: 4] = 4'(e);
        load(pack_cfg(sels, 4'hF, {4{16'hAAAA}}));
        do_reset();
        pin_in = 10'h00F;
        @(negedge clk);
        #1;
        chk("R7 one-cycle latency", 32'(pin_out), 32'hF);
        pin_in = 10'h005;
        #1;
        chk("R7 holds between edges", 32'(pin_out), 32'hF);
        @(negedge clk);
        #1;
        chk("R7 next capture", 32'(pin_out), 32'h5);

        // R6: random unregistered configurations
        for (int c = 0; c < 12; c++) begin
            load(rand_cfg(4'h0));
            do_reset();
            for (int n = 0; n < 30; n++) step(10'($urandom), "R6 comb random");
        end

        // R7 / R5: random registered configurations with feedback
        for (int c = 0; c < 12; c++) begin
            load(rand_cfg(4'hF));
            do_reset();
            for (int n = 0; n < 40; n++) step(10'($urandom), "R7 reg random");
        end

        // R9 / R6 / R7: mixed configurations
        for (int c = 0; c < 16; c++) begin
            load(rand_cfg(4'($urandom)));
            do_reset();
            for (int n = 0; n < 40; n++) step(10'($urandom), "R9 mixed random");
        end

        // R8: mid-run reset keeps the loaded function
        load(rand_cfg(4'hF));
        do_reset();
        for (int n = 0; n < 10; n++) step(10'($urandom), "R8 before reset");
        do_reset();
        #1;
        chk("R8 cleared mid-run", 32'(pin_out), 32'h0);
        for (int n = 0; n < 20; n++) step(10'($urandom), "R8 config kept");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule